// File: doc/BRIEF.md
# Strided Vector Load/Store Address Sequencer

This block turns one vectorised load or store into a stream of per-element effective addresses. A one-cycle `start` pulse latches these values:

- whether the operation is a load or a store;
- a stride mode;
- a 16-bit signed displacement;
- a 64-bit base value;
- an access width in bytes;
- a 7-bit vector length.

The block then walks the elements from index 0 upward. For each element it offers the index, the rewritten displacement and the effective address on a valid/ready handshake. After the last element has been accepted it pulses `done`.

How the displacement is rewritten depends on the stride mode. In unit-stride mode, the element step times the access width is added to it. In element-stride mode, it is multiplied by the element step. In any other mode it passes through unchanged. A load takes its step from a source counter and a store from a destination counter. Without predication the two counters move in lockstep, so loads and stores produce the same sequence.

Top module: `vec_ldst_agen`

## Requirements
- R1: The 16-bit displacement is sign-extended before any use, so 0xFFFC behaves as -4.
- R2: In normal mode (`mode_in` = 2'b00) every element carries the unchanged sign-extended displacement.
- R3: In unit-stride mode (`mode_in` = 2'b01) element k carries displacement imm + k*width, held as 32 bits.
- R4: In element-stride mode (`mode_in` = 2'b10) element k carries displacement imm*k, held as 32 bits.
- R5: `mode_in` = 2'b11 behaves exactly as normal mode.
- R6: `out_addr` equals the base plus the 32-bit displacement sign-extended to 64 bits, wrapping modulo 2^64.
- R7: Elements are offered in order 0..vlen-1, one per accepted handshake (`out_valid` and `out_ready` both high at a clock edge), for loads and stores alike.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold still.
- R9: `done` is high for exactly one cycle, in the cycle after the last element is accepted, and never together with `out_valid`. With a vector length of 0, no element is offered and `done` is high in the cycle after `start`.
- R10: `start` is taken only while neither `out_valid` nor `done` is high. At other times it has no effect on the sequence in progress.
- R11: After reset, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for a new vector operation |
| is_store | input | 1 | 1 = store (destination step), 0 = load (source step) |
| mode_in | input | 2 | 00 normal, 01 unit stride, 10 element stride, 11 normal |
| disp_in | input | 16 | Signed displacement field |
| base_in | input | 64 | Base address |
| width_in | input | 4 | Access width in bytes |
| vlen_in | input | 7 | Number of elements |
| out_valid | output | 1 | Element outputs are valid |
| out_ready | input | 1 | Consumer accepts the current element |
| out_index | output | 7 | Element index |
| out_disp | output | 32 | Adjusted displacement |
| out_addr | output | 64 | Effective address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the handshake on every cycle:

- outputs hold while stalled;
- the index starts at 0 and climbs by one per acceptance;
- `out_valid` only ever drops through a `done` pulse;
- `done` lasts one cycle and never overlaps `out_valid`.

The arithmetic can only be shown by the directed scenarios. These cover the sign extension, the three displacement rules, the reserved mode, address wrap-around, a zero-length vector and a `start` arriving mid-sequence. Each scenario compares the outputs with values computed in the bench.

// File: rtl/vec_ldst_agen.sv
module vec_ldst_agen #(
  parameter int AW = 64,
  parameter int IW = 16,
  parameter int OW = 32,
  parameter int LW = 7,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_store,
  input  logic [1:0]    mode_in,
  input  logic [IW-1:0] disp_in,
  input  logic [AW-1:0] base_in,
  input  logic [WW-1:0] width_in,
  input  logic [LW-1:0] vlen_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_index,
  output logic [OW-1:0] out_disp,
  output logic [AW-1:0] out_addr,
  output logic          done
);
  localparam logic [1:0] M_UNIT = 2'b01;
  localparam logic [1:0] M_ELEM = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;

  logic          st_q;
  logic [1:0]    mode_q;
  logic [OW-1:0] imm_q;
  logic [AW-1:0] base_q;
  logic [WW-1:0] width_q;
  logic [LW-1:0] vlen_q;
  logic [LW-1:0] src_q, dst_q;

  logic [LW-1:0] step;
  logic [OW-1:0] step_w;
  logic          fire, last, take;

  assign step   = st_q ? dst_q : src_q;
  assign step_w = OW'(step);
  assign fire   = (state == S_RUN) && out_ready;
  assign last   = step == vlen_q - LW'(1);
  assign take   = start && (state == S_IDLE);

  always_comb begin
    case (mode_q)
      M_UNIT:  out_disp = imm_q + step_w * OW'(width_q);
      M_ELEM:  out_disp = imm_q * step_w;
      default: out_disp = imm_q;
    endcase
  end

  assign out_addr  = base_q + {{(AW-OW){out_disp[OW-1]}}, out_disp};
  assign out_index = step;
  assign out_valid = state == S_RUN;
  assign done      = state == S_FIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      st_q    <= 1'b0;
      mode_q  <= '0;
      imm_q   <= '0;
      base_q  <= '0;
      width_q <= '0;
      vlen_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          st_q    <= is_store;
          mode_q  <= mode_in;
          imm_q   <= {{(OW-IW){disp_in[IW-1]}}, disp_in};
          base_q  <= base_in;
          width_q <= width_in;
          vlen_q  <= vlen_in;
          src_q   <= '0;
          dst_q   <= '0;
          state   <= (vlen_in == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (fire) begin
          if (last) begin
            state <= S_FIN;
          end else begin
            src_q <= src_q + LW'(1);
            dst_q <= dst_q + LW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_ldst_agen_chk.sv
module vec_ldst_agen_chk #(
  parameter int AW = 64,
  parameter int OW = 32,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] out_index,
  input logic [OW-1:0] out_disp,
  input logic [AW-1:0] out_addr,
  input logic          done
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_disp) && $stable(out_addr));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  a_r7_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_index == '0);

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> done || (out_valid && out_index == $past(out_index) + LW'(1)));

  a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid || done);
endmodule

bind vec_ldst_agen vec_ldst_agen_chk #(.AW(AW), .OW(OW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_index(out_index), .out_disp(out_disp), .out_addr(out_addr), .done(done));

// File: tb/tb_vec_ldst_agen.sv
module tb_vec_ldst_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_store = 1'b0;
  logic [1:0]  mode_in = '0;
  logic [15:0] disp_in = '0;
  logic [63:0] base_in = '0;
  logic [3:0]  width_in = '0;
  logic [6:0]  vlen_in = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, done;
  logic [6:0]  out_index;
  logic [31:0] out_disp;
  logic [63:0] out_addr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  vec_ldst_agen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .mode_in(mode_in),
    .disp_in(disp_in), .base_in(base_in), .width_in(width_in), .vlen_in(vlen_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_disp(out_disp), .out_addr(out_addr), .done(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_disp(input logic [1:0] m, input logic [15:0] imm,
                                           input int k, input int w);
    logic [31:0] s;
    s = {{16{imm[15]}}, imm};
    if (m == 2'b01) return s + 32'(k * w);
    if (m == 2'b10) return s * 32'(k);
    return s;
  endfunction

  task automatic run_vec(input string req, input bit st, input logic [1:0] m,
                         input logic [15:0] imm, input logic [63:0] base,
                         input logic [3:0] w, input int vl, input bit stall, input bit poke);
    logic [31:0] ed;
    logic [63:0] ea;
    @(negedge clk);
    is_store = st; mode_in = m; disp_in = imm; base_in = base; width_in = w;
    vlen_in = 7'(vl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    is_store = ~st; mode_in = ~m; disp_in = ~imm; base_in = ~base; width_in = ~w; vlen_in = ~7'(vl);
    if (vl == 0) begin
      chk(done && !out_valid, {req, " zero-length done"}, {62'd0, done, out_valid}, 64'd2);
    end
    for (int e = 0; e < vl; e++) begin
      ed = exp_disp(m, imm, e, int'(w));
      ea = base + {{32{ed[31]}}, ed};
      if (stall && (e % 2 == 1)) begin
        out_ready = 1'b0;
        start = poke;
        @(negedge clk);
        start = 1'b0;
        chk(out_valid && out_addr == ea, {req, " R8 hold"}, out_addr, ea);
      end
      chk(out_valid && out_index == 7'(e), {req, " index"}, {57'd0, out_index}, 64'(e));
      chk(out_disp == ed, {req, " disp"}, {32'd0, out_disp}, {32'd0, ed});
      chk(out_addr == ea, {req, " addr"}, out_addr, ea);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    if (vl != 0) chk(done && !out_valid, {req, " R9 done after last"}, {62'd0, done, out_valid}, 64'd2);
    @(negedge clk);
    chk(!done && !out_valid, {req, " R9 done one cycle"}, {62'd0, done, out_valid}, 64'd0);
  endtask

  task automatic t_reset;
    chk(!out_valid && !done, "R11 reset idle", {62'd0, out_valid, done}, 64'd0);
  endtask

  task automatic t_unit_example;
    run_vec("R3 R6 store", 1'b1, 2'b01, 16'd8, 64'h10, 4'd4, 2, 1'b0, 1'b0);
    run_vec("R3 R7 load", 1'b0, 2'b01, 16'd8, 64'h10, 4'd4, 2, 1'b0, 1'b0);
  endtask

  task automatic t_normal_negative;
    run_vec("R1 R2 normal", 1'b0, 2'b00, 16'hFFFC, 64'h100, 4'd8, 3, 1'b1, 1'b0);
  endtask

  task automatic t_elem_stride;
    run_vec("R4 elem", 1'b1, 2'b10, 16'h0010, 64'h2000, 4'd8, 5, 1'b1, 1'b0);
    run_vec("R4 R1 elem neg", 1'b0, 2'b10, 16'h8000, 64'h0, 4'd2, 4, 1'b0, 1'b0);
  endtask

  task automatic t_unit_negative_wrap;
    run_vec("R3 R1 unit neg", 1'b1, 2'b01, 16'hFFF8, 64'h40, 4'd4, 4, 1'b0, 1'b0);
    run_vec("R6 wrap", 1'b0, 2'b01, 16'h0020, 64'hFFFF_FFFF_FFFF_FFF0, 4'd8, 3, 1'b0, 1'b0);
    run_vec("R6 wrap down", 1'b0, 2'b00, 16'hFFF0, 64'h8, 4'd1, 1, 1'b0, 1'b0);
  endtask

  task automatic t_reserved_mode;
    run_vec("R5 mode 11", 1'b1, 2'b11, 16'h0123, 64'h1000, 4'd4, 3, 1'b0, 1'b0);
  endtask

  task automatic t_zero_len;
    run_vec("R9 vlen 0", 1'b0, 2'b01, 16'd8, 64'h10, 4'd4, 0, 1'b0, 1'b0);
  endtask

  task automatic t_start_ignored;
    run_vec("R10 start busy", 1'b1, 2'b01, 16'd4, 64'h3000, 4'd2, 6, 1'b1, 1'b1);
    @(negedge clk);
    chk(!out_valid && !done, "R10 no extra run", {62'd0, out_valid, done}, 64'd0);
  endtask

  task automatic t_max_len;
    run_vec("R7 max length", 1'b0, 2'b01, 16'd0, 64'h0, 4'd1, 127, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unit_example();
    t_normal_negative();
    t_elem_stride();
    t_unit_negative_wrap();
    t_reserved_mode();
    t_zero_len();
    t_start_ignored();
    t_max_len();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule